// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor over several clock cycles and returns a quotient, a remainder and a rounding flag. The three operand widths (dividend, divisor, quotient) are independent parameters. The remainder always has the divisor's width. A one-cycle `start` pulse captures the operands and begins a division. The result is announced by a one-cycle `done` pulse, or by an `err` pulse instead of `done`, a fixed number of enabled cycles later.

The core uses restoring shift-subtract. The first enabled cycle after `start` sets up the partial remainder and checks whether the quotient can fit. Each following enabled cycle produces one quotient bit, most significant bit first. A clock enable `ce` freezes the whole sequence when low. `start` acts even while `ce` is low, and `rst` overrides both. The parameter `ROUND_UP` selects whether the quotient is bumped by one when the remainder exceeds half the divisor. Fractional quotients are obtained by padding the dividend with zeros on the right.

Top module: `udiv_seq`

## Requirements
- R1: When `done` pulses, `quo` equals floor(`num`/`den`) and `rem` equals `num` mod `den` for the operands captured by the last `start`. With `ROUND_UP`=1, `quo` is that value plus `rnd`.
- R2: `done` or `err` rises exactly QW+1 enabled clock edges after the edge that sampled `start`, for exactly one cycle. Never both are high at once. `busy` is high from the edge after `start` until the pulse, and low from then on.
- R3: If `den` is zero, or the true quotient is 2^QW or more, `err` pulses in place of `done`.
- R4: If the resulting quotient (after any rounding) is zero, `err` pulses in place of `done`.
- R5: `rnd` is 1 exactly when the remainder is greater than half the divisor, that is, when 2*`rem` > `den`.
- R6: With `ROUND_UP`=1, the quotient is incremented when `rnd` is 1. If that increment overflows QW bits, `err` pulses instead of `done`. With `ROUND_UP`=0, the quotient is never incremented.
- R7: While `ce` is low and `start` is low, the division does not advance. Each such cycle delays the pulse by one cycle, and no pulse appears during the stall.
- R8: `start` begins a division even when `ce` is low. A `start` during a running division abandons it, and the result that follows belongs to the new operands.
- R9: `rst` returns the block to idle: `busy`, `done`, `err`, `quo`, `rem` and `rnd` are 0. `rst` takes precedence over `start`.
- R10: `quo`, `rem` and `rnd` keep their values after the pulse until the next division completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture operands and begin a division |
| ce | input | 1 | Clock enable; state is frozen when low and `start` is low |
| num | input | DW | Unsigned dividend |
| den | input | DVW | Unsigned divisor |
| quo | output | QW | Quotient (rounded if `ROUND_UP`=1) |
| rem | output | DVW | Remainder |
| rnd | output | 1 | Remainder exceeds half the divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | One-cycle pulse in place of `done` on overflow or zero quotient |

## Verification
The bench builds two copies with DW=6, DVW=3 and QW=4, one with `ROUND_UP`=0 and one with `ROUND_UP`=1, and drives them in parallel. With these widths all 512 operand pairs can be swept. The sweep covers the zero divisor, quotients of exactly 2^QW, zero quotients, remainders exactly at half the divisor, and a rounding increment that carries out of 15. Directed runs add stalls on `ce`, a start while `ce` is low, a restart during a run, and reset both during a run and together with `start`.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PREP = 2'd1,
      PH_RUN  = 2'd2
   } phase_t;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
   import udiv_pkg::*;
#(
   parameter int QW = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic ce,
   input  logic errc,
   output logic init,
   output logic step,
   output logic fin,
   output logic busy,
   output logic done,
   output logic err
);
   localparam int CW = (QW > 1) ? $clog2(QW) : 1;

   phase_t        ph;
   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt == CW'(QW - 1));
   assign init = (ph == PH_PREP) && ce && !start;
   assign step = (ph == PH_RUN) && ce && !start;
   assign fin  = step && last;
   assign busy = (ph != PH_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph   <= PH_IDLE;
         cnt  <= '0;
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         done <= fin && !errc;
         err  <= fin && errc;
         if (start) begin
            ph  <= PH_PREP;
            cnt <= '0;
         end else if (ce) begin
            case (ph)
               PH_PREP: begin
                  ph  <= PH_RUN;
                  cnt <= '0;
               end
               PH_RUN: begin
                  if (last) ph <= PH_IDLE;
                  else      cnt <= cnt + CW'(1);
               end
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      (done || err) |=> !(done || err));
   assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
      start |=> busy);
   assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && !ce && !start) |=> ($stable(cnt) && $stable(ph) && !done && !err));
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
   parameter int DW  = 16,
   parameter int DVW = 16,
   parameter int QW  = 16
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           init,
   input  logic           step,
   input  logic [DW-1:0]  num,
   input  logic [DVW-1:0] den,
   output logic [DW-1:0]  num_q,
   output logic [DVW-1:0] den_q,
   output logic           ovf,
   output logic [QW-1:0]  q_next,
   output logic [DVW-1:0] r_next
);
   localparam int XW = DW + QW + DVW;

   logic [XW-1:0]  ext;
   logic [XW-1:0]  hi;
   logic [DVW-1:0] p;
   logic [QW-1:0]  lo;
   logic [QW-1:0]  q;
   logic [DVW:0]   trial;
   logic           fits;

   assign ext    = XW'(num_q);
   assign hi     = ext >> QW;
   assign trial  = {p, lo[QW-1]};
   assign fits   = (trial >= {1'b0, den_q});
   assign r_next = fits ? DVW'(trial - {1'b0, den_q}) : DVW'(trial);
   assign q_next = QW'({q, fits});

   always_ff @(posedge clk) begin
      if (rst) begin
         num_q <= '0;
         den_q <= '0;
         ovf   <= 1'b0;
         p     <= '0;
         lo    <= '0;
         q     <= '0;
      end else if (load) begin
         num_q <= num;
         den_q <= den;
      end else if (init) begin
         ovf <= (den_q == '0) || (hi >= XW'(den_q));
         p   <= DVW'(hi);
         lo  <= QW'(ext);
         q   <= '0;
      end else if (step) begin
         p  <= r_next;
         lo <= lo << 1;
         q  <= q_next;
      end
   end

   assert_rem_bound_R1: assert property (@(posedge clk) disable iff (rst)
      (step && !ovf) |-> (p < den_q));
endmodule

// File: rtl/udiv_result.sv
module udiv_result #(
   parameter int DVW      = 16,
   parameter int QW       = 16,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           fin,
   input  logic           ovf,
   input  logic [QW-1:0]  q_next,
   input  logic [DVW-1:0] r_next,
   input  logic [DVW-1:0] den_q,
   output logic           errc,
   output logic [QW-1:0]  quo,
   output logic [DVW-1:0] rem,
   output logic           rnd
);
   logic          rnd_n;
   logic [QW-1:0] qf;
   logic          carry;

   assign rnd_n = ({r_next, 1'b0} > {1'b0, den_q});

   generate
      if (ROUND_UP) begin : g_round
         assign {carry, qf} = {1'b0, q_next} + (QW + 1)'(rnd_n);
      end else begin : g_trunc
         assign carry = 1'b0;
         assign qf    = q_next;
      end
   endgenerate

   assign errc = ovf || carry || (qf == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         quo <= '0;
         rem <= '0;
         rnd <= 1'b0;
      end else if (fin) begin
         quo <= qf;
         rem <= r_next;
         rnd <= rnd_n;
      end
   end
endmodule

// File: rtl/udiv_seq.sv
module udiv_seq #(
   parameter int DW       = 16,
   parameter int DVW      = 16,
   parameter int QW       = 16,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           ce,
   input  logic [DW-1:0]  num,
   input  logic [DVW-1:0] den,
   output logic [QW-1:0]  quo,
   output logic [DVW-1:0] rem,
   output logic           rnd,
   output logic           busy,
   output logic           done,
   output logic           err
);
   localparam int PW = DW + QW + DVW + 1;

   generate
      if (DW < 1 || DVW < 1 || QW < 1) begin : g_bad_width
         $error("udiv_seq: all widths must be at least 1");
      end
   endgenerate

   logic           init_w, step_w, fin_w, errc_w, ovf_w;
   logic [DW-1:0]  num_q;
   logic [DVW-1:0] den_q;
   logic [QW-1:0]  q_next;
   logic [DVW-1:0] r_next;

   udiv_ctrl #(.QW(QW)) u_ctrl (
      .clk(clk), .rst(rst), .start(start), .ce(ce), .errc(errc_w),
      .init(init_w), .step(step_w), .fin(fin_w),
      .busy(busy), .done(done), .err(err)
   );

   udiv_core #(.DW(DW), .DVW(DVW), .QW(QW)) u_core (
      .clk(clk), .rst(rst), .load(start), .init(init_w), .step(step_w),
      .num(num), .den(den), .num_q(num_q), .den_q(den_q), .ovf(ovf_w),
      .q_next(q_next), .r_next(r_next)
   );

   udiv_result #(.DVW(DVW), .QW(QW), .ROUND_UP(ROUND_UP)) u_res (
      .clk(clk), .rst(rst), .fin(fin_w), .ovf(ovf_w),
      .q_next(q_next), .r_next(r_next), .den_q(den_q),
      .errc(errc_w), .quo(quo), .rem(rem), .rnd(rnd)
   );

   logic [QW-1:0] q_raw;
   assign q_raw = quo - QW'(ROUND_UP && rnd);

   assert_div_identity_R1: assert property (@(posedge clk) disable iff (rst)
      done |-> (PW'(q_raw) * PW'(den_q) + PW'(rem) == PW'(num_q)));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      done |-> !ovf_w);
   assert_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
      done |-> (quo != '0));
   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !fin_w |=> ($stable(quo) && $stable(rem) && $stable(rnd)));
endmodule

// File: tb/sim_udiv_seq.sv
`timescale 1ns/1ps
module sim_udiv_seq;
   localparam int DW = 6, DVW = 3, QW = 4;
   localparam int QMAX = (1 << QW) - 1;

   logic clk = 1'b0, rst = 1'b1, start = 1'b0, ce = 1'b0;
   logic [DW-1:0]  num = '0;
   logic [DVW-1:0] den = '0;
   logic [QW-1:0]  quo0, quo1;
   logic [DVW-1:0] rem0, rem1;
   logic           rnd0, rnd1, busy0, busy1, done0, done1, err0, err1;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   udiv_seq #(.DW(DW), .DVW(DVW), .QW(QW), .ROUND_UP(1'b0)) u0 (
      .clk(clk), .rst(rst), .start(start), .ce(ce), .num(num), .den(den),
      .quo(quo0), .rem(rem0), .rnd(rnd0), .busy(busy0), .done(done0), .err(err0));
   udiv_seq #(.DW(DW), .DVW(DVW), .QW(QW), .ROUND_UP(1'b1)) u1 (
      .clk(clk), .rst(rst), .start(start), .ce(ce), .num(num), .den(den),
      .quo(quo1), .rem(rem1), .rnd(rnd1), .busy(busy1), .done(done1), .err(err1));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // check both instances at the pulse cycle
   task automatic check_result(input int n, input int d);
      bit ovf; int q, r, rn, q1; bit e0, e1; string tag;
      ovf = (d == 0) || ((n / d) > QMAX);
      q   = ovf ? 0 : n / d;
      r   = ovf ? 0 : n % d;
      rn  = (2 * r > d) ? 1 : 0;
      e0  = ovf || (q == 0);
      q1  = q + rn;
      e1  = ovf || (q1 == 0) || (q1 > QMAX);
      tag = ovf ? "R3" : (q == 0 ? "R4" : "R2");
      chk(err0 == e0 && done0 == !e0, tag, "u0 err", int'(err0), int'(e0));
      chk(err1 == e1 && done1 == !e1, "R6", "u1 err", int'(err1), int'(e1));
      if (!e0) begin
         chk(int'(quo0) == q, "R1", "u0 quo", int'(quo0), q);
         chk(int'(rem0) == r, "R1", "u0 rem", int'(rem0), r);
         chk(int'(rnd0) == rn, "R5", "u0 rnd", int'(rnd0), rn);
      end
      if (!e1) begin
         chk(int'(quo1) == q1, "R6", "u1 quo", int'(quo1), q1);
         chk(int'(rem1) == r, "R1", "u1 rem", int'(rem1), r);
      end
   endtask

   // after the pulse: gone, idle, values held
   task automatic check_after;
      logic [QW-1:0] hq0, hq1; logic [DVW-1:0] hr0; logic hn0;
      hq0 = quo0; hq1 = quo1; hr0 = rem0; hn0 = rnd0;
      @(negedge clk);
      chk(!done0 && !err0 && !done1 && !err1 && !busy0 && !busy1, "R2",
          "pulse width/busy", int'(done0 | err0), 0);
      repeat (2) @(negedge clk);
      chk(quo0 == hq0 && quo1 == hq1 && rem0 == hr0 && rnd0 == hn0, "R10",
          "held quo", int'(quo0), int'(hq0));
   endtask

   // wait for QW+1 enabled edges, ce following stall pattern (bit i = low at step i)
   task automatic wait_pulse(input int n, input int d, input int stall_mask);
      int en_seen = 0; bit early = 0;
      for (int i = 0; i < 60; i++) begin
         bit c; c = !stall_mask[i % 32];
         ce = c;
         @(negedge clk);
         if (c) en_seen++;
         if (en_seen >= QW + 1) break;
         if (done0 || err0 || done1 || err1 || !busy0) early = 1;
      end
      chk(!early, (stall_mask != 0) ? "R7" : "R2", "no early pulse", int'(early), 0);
      check_result(n, d);
      ce = 1'b1;
   endtask

   task automatic issue(input int n, input int d, input bit c);
      @(negedge clk);
      num = DW'(n); den = DVW'(d); start = 1'b1; ce = c;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy0 && !done0 && !err0 && quo0 == 0 && rem0 == 0 && !rnd0 && !busy1,
          "R9", "reset state", int'(busy0), 0);
      rst = 1'b0;

      // exhaustive sweep
      for (int n = 0; n < (1 << DW); n++) begin
         for (int d = 0; d < (1 << DVW); d++) begin
            issue(n, d, 1'b1);
            chk(busy0 && busy1, "R2", "busy after start", int'(busy0), 1);
            wait_pulse(n, d, 0);
            check_after();
         end
      end

      // R7: stalls in the middle of a run
      issue(47, 6, 1'b1);
      wait_pulse(47, 6, 32'b0101_1100);
      check_after();

      // R8: start while ce low, stay low for two cycles
      issue(45, 4, 1'b0);
      @(negedge clk);
      chk(busy0 && !done0 && !err0, "R8", "start with ce low", int'(busy0), 1);
      wait_pulse(45, 4, 32'b1);
      check_after();

      // R8: restart during a run
      issue(63, 7, 1'b1);
      repeat (2) @(negedge clk);
      issue(50, 4, 1'b1);
      wait_pulse(50, 4, 0);
      check_after();

      // R9: reset during a run
      issue(30, 5, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!busy0 && quo0 == 0 && rem0 == 0 && !rnd0, "R9", "reset mid-run",
          int'(busy0), 0);
      begin
         bit seen = 0;
         repeat (QW + 4) begin
            @(negedge clk);
            if (done0 || err0 || busy0) seen = 1;
         end
         chk(!seen, "R9", "no pulse after reset", int'(seen), 0);
      end

      // R9: reset wins over start
      @(negedge clk);
      num = 6'd20; den = 3'd3; start = 1'b1; rst = 1'b1;
      @(negedge clk);
      start = 1'b0; rst = 1'b0;
      chk(!busy0 && !busy1, "R9", "reset over start", int'(busy0), 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule